// File: doc/BRIEF.md
# Successive-Approximation Converter Control Unit

This unit is the digital side of a 10-bit successive-approximation analog-to-digital converter that hangs off an 8-bit processor bus. Software programs one control/status byte: a 4-bit channel number, an enable bit, a clock-speed bit and a hardware-owned completion flag. From the processor clock the unit derives a conversion clock. It then runs a sample phase and ten trial phases against an external comparator, presenting each trial code to the converter's DAC, and places the finished code into two readable result bytes.

Once enabled, the unit converts the selected channel without pause, so software always finds the most recent result. Changing the channel number aborts the conversion that is running and restarts on the new input. A halt input powers the converter down. After halt is released, a stabilisation count of conversion-clock periods must expire before any sampling is allowed, and a status output reports when that count has run out.

Top module: `adc_ctrl_unit`

## Requirements
- R1: After reset the control byte (address 0), the high result byte (address 1) and the low result byte (address 2) all read 0x00, `adc_pwr` and `sample_en` are 0 and `stable` is 1. Address 3 always reads 0x00.
- R2: Control byte layout: bit 7 is the completion flag, bit 6 is speed, bit 5 is enable, bit 4 is reserved and bits 3:0 are the channel. Writes to bits 6, 5 and 3:0 read back. Bit 4 always reads 0. Writes to bit 7 are ignored.
- R3: The completion flag is set when a conversion finishes. It is cleared by a read strobe on address 1 or by any write to address 0. A read strobe on address 2 leaves it unchanged.
- R4: One conversion-clock period is 4 processor cycles when speed is 0 and 2 when speed is 1. In continuous operation, completions are 11 conversion-clock periods apart.
- R5: A conversion is one sample period (`sample_en` high) followed by ten trial periods, MSB first. A trial bit is kept when `cmp_in` is 1 (input at or above `dac_code`). With an ideal comparator the result equals the input code.
- R6: Address 1 returns result bits 9:2. Address 2 returns result bits 1:0 in its bits 1:0, with bits 7:2 at zero. Both bytes change together, only when a conversion finishes.
- R7: While enable stays set, a new conversion on the same channel starts right after each completion, with no software action.
- R8: A control write that changes the channel aborts the running conversion, clears the flag and restarts on the new channel: the next completion comes 11 to 12 conversion-clock periods after the write. A write that keeps the channel does not disturb the running sequence.
- R9: Clearing enable stops the conversion, drives `adc_pwr` low and prevents any further completion or sampling.
- R10: While `halt_req` is high, `adc_pwr` and `stable` are low and no conversion runs. After release, `stable` rises once STAB_TICKS conversion-clock periods have passed, sampling stays off until then, and conversion then resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, used for read side effects |
| bus_addr | input | 2 | Register address: 0 control, 1 result high, 2 result low |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| halt_req | input | 1 | Low-power halt request |
| cmp_in | input | 1 | Comparator: 1 when the analog input is at or above the DAC level |
| dac_code | output | 10 | Trial code for the DAC, zero outside trial periods |
| adc_chan | output | 4 | Selected input channel |
| sample_en | output | 1 | High during the sample period |
| adc_pwr | output | 1 | Converter power enable |
| stable | output | 1 | High when the converter is out of halt and settled |

## Verification
The assertions assume that `cmp_in` is a function of `dac_code` and the selected channel that settles within the same cycle, and that bus strobes are single-cycle pulses. They also assume that `halt_req` changes only between clock edges. The bench models each channel as a fixed 10-bit input code and computes `cmp_in` combinationally from `adc_chan` and `dac_code`. It changes an input code only in the half cycle after a completion is seen, which is well before the next trial period compares it. All bus strobes and `halt_req` edges are driven on the falling clock edge.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;
  localparam int RES_W   = 10;
  localparam int IDX_W   = $clog2(RES_W);
  localparam int CH_W    = 4;
  localparam int ADDR_W  = 2;
  localparam int B_FLAG  = 7;
  localparam int B_SPEED = 6;
  localparam int B_ON    = 5;

  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_HI   = 2'd1;
  localparam logic [ADDR_W-1:0] A_LO   = 2'd2;

  typedef enum logic [1:0] {SAR_IDLE, SAR_SAMPLE, SAR_CONV} sar_state_e;

  function automatic logic [RES_W-1:0] trial_mask(input logic [IDX_W-1:0] i);
    return RES_W'(1) << i;
  endfunction

  function automatic logic [7:0] res_hi(input logic [RES_W-1:0] r);
    return r[RES_W-1:RES_W-8];
  endfunction

  function automatic logic [7:0] res_lo(input logic [RES_W-1:0] r);
    return {6'b0, r[1:0]};
  endfunction
endpackage

// File: rtl/adc_clk_div.sv
module adc_clk_div #(
  parameter int DIV_SLOW = 4,
  parameter int DIV_FAST = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic speed,
  output logic tick
);
  localparam int CNT_W = $clog2(DIV_SLOW + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;

  assign limit = speed ? CNT_W'(DIV_FAST - 1) : CNT_W'(DIV_SLOW - 1);
  assign tick  = (cnt >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

  // R4: both divide ratios are at least two, so ticks never come back to back
  a_r4_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/adc_stab_timer.sv
module adc_stab_timer #(
  parameter int STAB_TICKS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic halt,
  input  logic tick,
  output logic stable
);
  localparam int CW = $clog2(STAB_TICKS + 1);

  logic [CW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      remain <= '0;
    else if (halt)                   remain <= CW'(STAB_TICKS);
    else if (tick && remain != '0)   remain <= remain - 1'b1;
  end

  assign stable = !halt && (remain == '0);

  // R10: leaving halt never reports a settled converter at once
  a_r10_low_after_wake: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(halt) |-> !stable);
  // R10: the settled status only appears after a conversion-clock period
  a_r10_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stable) |-> $past(tick));
endmodule

// File: rtl/adc_sar_seq.sv
module adc_sar_seq
  import adc_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             enable,
  input  logic             restart,
  input  logic             cmp_in,
  output logic [RES_W-1:0] dac_code,
  output logic             sample_en,
  output logic             done,
  output logic [RES_W-1:0] result
);
  localparam logic [IDX_W-1:0] TOP = IDX_W'(RES_W - 1);

  sar_state_e       st;
  logic [IDX_W-1:0] idx;
  logic [RES_W-1:0] approx;
  logic [RES_W-1:0] mask;
  logic [RES_W-1:0] keep;
  logic             last;

  assign mask      = trial_mask(idx);
  assign keep      = cmp_in ? (approx | mask) : approx;
  assign last      = (idx == '0);
  assign dac_code  = (st == SAR_CONV) ? (approx | mask) : '0;
  assign sample_en = (st == SAR_SAMPLE);
  assign result    = keep;
  assign done      = tick && enable && !restart && (st == SAR_CONV) && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= SAR_IDLE;
      idx    <= TOP;
      approx <= '0;
    end else if (!enable || restart) begin
      st     <= SAR_IDLE;
      idx    <= TOP;
      approx <= '0;
    end else if (tick) begin
      unique case (st)
        SAR_IDLE:   st <= SAR_SAMPLE;
        SAR_SAMPLE: begin
          st     <= SAR_CONV;
          idx    <= TOP;
          approx <= '0;
        end
        SAR_CONV: begin
          if (last) begin
            st     <= SAR_SAMPLE;
            approx <= '0;
          end else begin
            approx <= keep;
            idx    <= idx - 1'b1;
          end
        end
        default: st <= SAR_IDLE;
      endcase
    end
  end

  // R5: the trial phase is always entered from the sample phase
  a_r5_sample_first: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SAR_CONV && $past(st) != SAR_CONV) |-> $past(st) == SAR_SAMPLE);
  // R4: the sequence only advances on a conversion-clock period
  a_r4_move_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && enable && !restart) |=> $stable(st));
  // R8: a channel change sends the sequence back to idle
  a_r8_restart_idle: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> st == SAR_IDLE);
  // R9: with the converter off the sequence parks in idle
  a_r9_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> st == SAR_IDLE);
endmodule

// File: rtl/adc_csr.sv
module adc_csr
  import adc_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic              done,
  input  logic [RES_W-1:0]  result,
  output logic              speed,
  output logic              adon,
  output logic [CH_W-1:0]   chan,
  output logic              chan_restart
);
  logic             eoc;
  logic [RES_W-1:0] res_q;
  logic             ctrl_wr;
  logic             hi_rd;
  logic             unused_wbits;

  assign ctrl_wr      = wr_en && (addr == A_CTRL);
  assign hi_rd        = rd_en && (addr == A_HI);
  assign chan_restart = ctrl_wr && (wdata[CH_W-1:0] != chan);
  assign unused_wbits = ^{wdata[B_FLAG], wdata[4]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      speed <= 1'b0;
      adon  <= 1'b0;
      chan  <= '0;
    end else if (ctrl_wr) begin
      speed <= wdata[B_SPEED];
      adon  <= wdata[B_ON];
      chan  <= wdata[CH_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    res_q <= '0;
    else if (done) res_q <= result;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  eoc <= 1'b0;
    else if (done)               eoc <= 1'b1;
    else if (ctrl_wr || hi_rd)   eoc <= 1'b0;
  end

  always_comb begin
    unique case (addr)
      A_CTRL:  rdata = {eoc, speed, adon, 1'b0, chan};
      A_HI:    rdata = res_hi(res_q);
      A_LO:    rdata = res_lo(res_q);
      default: rdata = 8'h00;
    endcase
  end

  // R3: the flag is only raised by a completion
  a_r3_flag_from_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eoc) |-> $past(done));
  // R3: a control write or high-byte read clears the flag
  a_r3_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ((ctrl_wr || hi_rd) && !done) |=> !eoc);
  // R6: the result bytes hold between completions
  a_r6_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(res_q));
endmodule

// File: rtl/adc_ctrl_unit.sv
module adc_ctrl_unit
  import adc_ctrl_pkg::*;
#(
  parameter int DIV_SLOW   = 4,
  parameter int DIV_FAST   = 2,
  parameter int STAB_TICKS = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [1:0]  bus_addr,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  input  logic        halt_req,
  input  logic        cmp_in,
  output logic [9:0]  dac_code,
  output logic [3:0]  adc_chan,
  output logic        sample_en,
  output logic        adc_pwr,
  output logic        stable
);
  logic             speed;
  logic             adon;
  logic             tick;
  logic             chan_restart;
  logic             conv_done;
  logic             run_ok;
  logic [RES_W-1:0] conv_result;

  adc_csr u_csr (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (bus_wr),
    .rd_en        (bus_rd),
    .addr         (bus_addr),
    .wdata        (bus_wdata),
    .rdata        (bus_rdata),
    .done         (conv_done),
    .result       (conv_result),
    .speed        (speed),
    .adon         (adon),
    .chan         (adc_chan),
    .chan_restart (chan_restart)
  );

  adc_clk_div #(.DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .speed (speed),
    .tick  (tick)
  );

  adc_stab_timer #(.STAB_TICKS(STAB_TICKS)) u_stab (
    .clk    (clk),
    .rst_n  (rst_n),
    .halt   (halt_req),
    .tick   (tick),
    .stable (stable)
  );

  assign run_ok  = adon && stable;
  assign adc_pwr = adon && !halt_req;

  adc_sar_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .enable    (run_ok),
    .restart   (chan_restart),
    .cmp_in    (cmp_in),
    .dac_code  (dac_code),
    .sample_en (sample_en),
    .done      (conv_done),
    .result    (conv_result)
  );

  // R10: no sampling while the converter is halted or settling
  a_r10_no_sample_unsettled: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en |-> stable);
  // R9: a powered-down converter never completes
  a_r9_no_done_unpowered: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |-> adc_pwr);
endmodule

// File: tb/adc_ctrl_unit_test.sv
module adc_ctrl_unit_test;
  localparam int STAB = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       halt_req = 1'b0;
  logic       cmp_in;
  logic [9:0] dac_code;
  logic [3:0] adc_chan;
  logic       sample_en, adc_pwr, stable;
  logic [9:0] vin [16];

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  assign cmp_in = (vin[adc_chan] >= dac_code);

  adc_ctrl_unit #(.DIV_SLOW(4), .DIV_FAST(2), .STAB_TICKS(STAB)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .halt_req(halt_req), .cmp_in(cmp_in), .dac_code(dac_code),
    .adc_chan(adc_chan), .sample_en(sample_en), .adc_pwr(adc_pwr),
    .stable(stable)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    bus_addr = 2'd0; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input bit strobe, output logic [7:0] d);
    bus_addr = a; bus_rd = strobe;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0; bus_addr = 2'd0;
  endtask

  task automatic wait_flag(output bit ok);
    ok = 1'b0;
    bus_addr = 2'd0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (bus_rdata[7]) begin ok = 1'b1; return; end
    end
  endtask

  function automatic logic [9:0] code_of(input int k, input int step, input int ch);
    return 10'((k * step + ch * 41) % 1024);
  endfunction

  // R5 R6 R7: continuous conversions, result compared with the modelled input
  task automatic sweep(input int ch, input bit fast, input int count, input int step);
    logic [7:0] hi, lo;
    bit ok;
    wr(8'h00);
    vin[ch] = code_of(0, step, ch);
    wr({1'b0, fast, 1'b1, 1'b0, 4'(ch)});
    for (int k = 0; k < count; k++) begin
      wait_flag(ok);
      check(ok, "R7 completion seen", ok, 1);
      if (!ok) return;
      vin[ch] = code_of(k + 1, step, ch);
      rd(2'd2, 1'b1, lo);
      rd(2'd1, 1'b1, hi);
      check({hi, lo[1:0]} == code_of(k, step, ch), "R5 result code",
            {hi, lo[1:0]}, code_of(k, step, ch));
      check(lo[7:2] == 6'd0, "R6 low byte upper bits", lo, lo & 8'h03);
    end
  endtask

  task automatic measure_period(input logic [7:0] ctrl, input int exp);
    bit ok;
    int n;
    wait_flag(ok);
    bus_addr = 2'd0; bus_wdata = ctrl; bus_wr = 1'b1;
    n = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      bus_wr = 1'b0;
      n++;
      if (bus_rdata[7]) break;
    end
    check(n == exp, "R4 R8 completion spacing", n, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d, hi, lo;
    bit ok;
    int n;
    bit bad;
    for (int i = 0; i < 16; i++) vin[i] = 10'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, 1'b0, d); check(d == 8'h00, "R1 control byte", d, 0);
    rd(2'd1, 1'b0, d); check(d == 8'h00, "R1 high byte", d, 0);
    rd(2'd2, 1'b0, d); check(d == 8'h00, "R1 low byte", d, 0);
    rd(2'd3, 1'b0, d); check(d == 8'h00, "R1 unused address", d, 0);
    check(stable && !adc_pwr && !sample_en, "R1 status pins",
          {stable, adc_pwr, sample_en}, 3'b100);

    // R2 layout, reserved bit and read-only flag
    wr(8'h10); rd(2'd0, 1'b0, d); check(d == 8'h00, "R2 reserved bit", d, 8'h00);
    wr(8'h9A); rd(2'd0, 1'b0, d); check(d == 8'h0A, "R2 flag not writable", d, 8'h0A);
    wr(8'hFF); rd(2'd0, 1'b0, d); check(d == 8'h6F, "R2 readback", d, 8'h6F);
    check(adc_chan == 4'hF && adc_pwr, "R2 channel pins", {adc_pwr, adc_chan}, 5'h1F);

    // R5 R6 R7 exhaustive sweep in fast mode, sparse sweeps in slow mode
    sweep(3, 1'b1, 1024, 1);
    measure_period(8'h63, 22);
    sweep(0, 1'b0, 12, 337);
    sweep(9, 1'b0, 12, 113);
    sweep(15, 1'b0, 12, 691);
    measure_period(8'h2F, 44);

    // R3 flag clearing rules
    wait_flag(ok);
    rd(2'd2, 1'b1, d);
    rd(2'd0, 1'b0, d); check(d[7], "R3 low read keeps flag", d[7], 1);
    rd(2'd1, 1'b1, d);
    rd(2'd0, 1'b0, d); check(!d[7], "R3 high read clears flag", d[7], 0);
    wait_flag(ok);
    wr(8'h2F);
    rd(2'd0, 1'b0, d); check(!d[7], "R3 control write clears flag", d[7], 0);

    // R8 channel change mid-conversion
    vin[2] = 10'h3FF; vin[5] = 10'h000;
    wr(8'h22);
    wait_flag(ok);
    repeat (12) @(negedge clk);
    bus_addr = 2'd0; bus_wdata = 8'h25; bus_wr = 1'b1;
    n = 0;
    @(negedge clk);
    bus_wr = 1'b0;
    check(!bus_rdata[7] && adc_chan == 4'd5, "R8 flag cleared and channel moved",
          {bus_rdata[7], adc_chan}, 5);
    for (int i = 0; i < 200; i++) begin
      n++;
      if (bus_rdata[7]) break;
      @(negedge clk);
    end
    check(n >= 44 && n <= 48, "R8 restart delay", n, 44);
    rd(2'd2, 1'b0, lo); rd(2'd1, 1'b0, hi);
    check({hi, lo[1:0]} == 10'h000, "R8 result of new channel", {hi, lo[1:0]}, 0);

    // R9 disable stops everything
    wr(8'h05);
    check(!adc_pwr, "R9 power off", adc_pwr, 0);
    bad = 1'b0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (bus_rdata[7] || sample_en) bad = 1'b1;
    end
    check(!bad, "R9 no activity while off", bad, 0);

    // R10 halt and stabilisation
    vin[1] = 10'h155;
    wr(8'h61);
    repeat (8) @(negedge clk);
    halt_req = 1'b1;
    @(negedge clk);
    check(!adc_pwr && !stable, "R10 halted status", {adc_pwr, stable}, 0);
    bad = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (bus_rdata[7] || sample_en || stable) bad = 1'b1;
    end
    check(!bad, "R10 idle during halt", bad, 0);
    halt_req = 1'b0;
    n = 0; bad = 1'b0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      n++;
      if (stable) break;
      if (sample_en) bad = 1'b1;
    end
    check(n >= 2 * STAB - 1 && n <= 2 * STAB, "R10 settle time", n, 2 * STAB);
    check(!bad, "R10 no sample while settling", bad, 0);
    wait_flag(ok);
    check(ok, "R10 conversion resumes", ok, 1);
    rd(2'd2, 1'b0, lo); rd(2'd1, 1'b0, hi);
    check({hi, lo[1:0]} == 10'h155, "R10 result after wake", {hi, lo[1:0]}, 10'h155);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule